// File: doc/BRIEF.md
# Charger Fault Protection Supervisor

This block is the digital side of a charger's protection scheme. It takes already-compared fault flags from analog circuits and decides when to raise one protection output. The flags are output overvoltage, a soft-short (system fault) monitor and a low thermal-sense level. Each flag must persist for its own time before it causes a trip. All times are counted in ticks. A prescaler divides the system clock down to one tick.

The block also tells the analog front end two things:
- which overvoltage threshold to apply, which follows the output set-point and the operating mode;
- when to switch on the thermal sense current.

Overvoltage detection is blanked for a while after the set-point steps down. The soft-short monitor is only armed when no device is attached, or when an attached device has asked for a check. After a trip, the block either latches until the supply is lost or releases by itself after a quiet interval. A configuration pin picks which.

The controller is a three-state machine:
- `S_MON`: monitoring.
- `S_HYS`: tripped, recovering.
- `S_LATCH`: tripped, latched.

Its transitions are:
- `S_MON -> S_HYS`: a fault is qualified and latching is off.
- `S_MON -> S_LATCH`: a fault is qualified and latching is on.
- `S_HYS -> S_MON`: the recovery interval completes.
- Any state `-> S_MON`: the supply-good input is low. This is a synchronous clear, and it also clears every counter.

Top module: `chg_prot_sup`

## Requirements
- R1: A high `ov_flag` outside blanking trips protection once it has stayed high for OV_TICKS consecutive ticks; `prot` rises on the clock after that. A shorter pulse leaves `prot` low.
- R2: Outside continuous mode, `ov_sel` equals the set-point code `setpt`. The codes are 0 = 5 V, 1 = 9 V, 2 = 12 V and 3 = 20 V; each selects a threshold of 120 % of that voltage.
- R3: In continuous mode, `ov_sel` is 4 (the 12 V class maximum) when `class_b` is 0, and 5 (the 20 V class maximum) when `class_b` is 1.
- R4: A `step_dn` pulse outside continuous mode blanks overvoltage detection for BLANK_TICKS ticks. A `step_dn` pulse in continuous mode has no effect on detection.
- R5: `sysmon_flag` trips protection after SYS_TICKS ticks, but only while `no_dev` or `remote_chk` is high. Otherwise it is ignored.
- R6: `therm_en` is high for the first TH_ON ticks of every TH_PER-tick period.
- R7: A high `therm_low` trips protection after TH_TICKS ticks during which `therm_en` was high. The count clears whenever `therm_low` goes low.
- R8: With `cfg_latch` high, `prot` stays high after a trip until `supply_ok` goes low, whatever the fault flags do.
- R9: With `cfg_latch` low, `prot` falls after RECOV_TICKS ticks during which `ov_flag`, the armed system fault and `therm_low` were all low.
- R10: While `supply_ok` is low, every state and counter is cleared and `prot` is low on the next clock.
- R11: A persistence count restarts from zero whenever its flag drops before the count completes. Two short pulses therefore do not add up to a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its undervoltage release level; low clears the block |
| ov_flag | input | 1 | Overvoltage comparator output |
| sysmon_flag | input | 1 | System fault monitor comparator output |
| therm_low | input | 1 | Thermal sense level below threshold |
| no_dev | input | 1 | No device attached (D+ below its detect level) |
| remote_chk | input | 1 | Attached device requested a system check |
| cont_mode | input | 1 | Continuous voltage adjustment mode active |
| class_b | input | 1 | 20 V class selected (0 = 12 V class) |
| setpt | input | 2 | Fixed set-point code (0 = 5 V, 1 = 9 V, 2 = 12 V, 3 = 20 V) |
| step_dn | input | 1 | One-cycle strobe: set-point stepped down |
| cfg_latch | input | 1 | 1 = latching shutdown, 0 = hysteretic |
| ov_sel | output | 3 | Overvoltage threshold selection |
| therm_en | output | 1 | Thermal sense current enable |
| prot | output | 1 | Protection output |

## Verification
The bench builds the block with:

| Parameter | Value |
|---|---|
| TICK_DIV | 4 |
| OV_TICKS | 3 |
| BLANK_TICKS | 10 |
| SYS_TICKS | 6 |
| TH_TICKS | 4 |
| TH_PER | 5 |
| TH_ON | 2 |
| RECOV_TICKS | 5 |

With these values every timing window (blanking expiry, thermal duty period, recovery release, restart of a partly completed count) spans tens of clocks. It can therefore be swept many times within a short run. Because the prescaler is not 1, the tests also cover how ticks line up with the flag edges, which a divide-by-one build would hide. A behavioural model in the bench tracks every tick and counter and is compared on each clock. Directed checks pin down the boundary cases.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [1:0] {
        S_MON   = 2'd0,
        S_HYS   = 2'd1,
        S_LATCH = 2'd2
    } prot_st_t;

    localparam logic [2:0] OVS_MAX_A = 3'd4;
    localparam logic [2:0] OVS_MAX_B = 3'd5;
endpackage

// File: rtl/cps_tick_gen.sv
module cps_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        cnt <= '0;
                else if (!run)     cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else               cnt <= cnt + 1'b1;
            end

            assign tick = run && (cnt == LAST);

            // R6: ticks are isolated single-cycle pulses when dividing
            p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cps_persist.sv
module cps_persist #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic flag,
    input  logic adv,
    output logic done
);
    localparam int W = $clog2(N + 1);
    localparam logic [W-1:0] LIM = W'(N);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run || !flag)     cnt <= '0;
        else if (adv && cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);

    // R11: a dropped flag leaves no partial count behind
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |=> !done);
endmodule

// File: rtl/cps_therm_sched.sv
module cps_therm_sched #(
    parameter int PER = 100,
    parameter int ON  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic sense_en
);
    localparam int W = $clog2(PER);
    localparam logic [W-1:0] LAST = W'(PER - 1);
    localparam logic [W-1:0] ONL  = W'(ON);

    logic [W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ph <= '0;
        else if (!run)    ph <= '0;
        else if (tick)    ph <= (ph == LAST) ? '0 : ph + 1'b1;
    end

    assign sense_en = (ph < ONL);

    // R6: the sense window opens only at the start of a period
    p_window_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_en) |-> (ph == '0));
endmodule

// File: rtl/chg_prot_sup.sv
module chg_prot_sup
    import cps_pkg::*;
#(
    parameter int TICK_DIV    = 125,
    parameter int OV_TICKS    = 50,
    parameter int BLANK_TICKS = 500000,
    parameter int SYS_TICKS   = 40000,
    parameter int TH_TICKS    = 1000,
    parameter int TH_PER      = 100,
    parameter int TH_ON       = 10,
    parameter int RECOV_TICKS = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       ov_flag,
    input  logic       sysmon_flag,
    input  logic       therm_low,
    input  logic       no_dev,
    input  logic       remote_chk,
    input  logic       cont_mode,
    input  logic       class_b,
    input  logic [1:0] setpt,
    input  logic       step_dn,
    input  logic       cfg_latch,
    output logic [2:0] ov_sel,
    output logic       therm_en,
    output logic       prot
);
    localparam int BW = $clog2(BLANK_TICKS + 1);
    localparam int RW = $clog2(RECOV_TICKS + 1);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_TICKS);
    localparam logic [RW-1:0] RECOV_LIM = RW'(RECOV_TICKS);

    logic tick;
    logic blanking, ov_done, sys_done, th_done, rec_done;
    logic sys_armed, any_flag;
    logic [BW-1:0] blank_cnt;
    logic [RW-1:0] rec_cnt;
    prot_st_t state, state_nx;

    cps_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(supply_ok), .tick(tick)
    );

    cps_therm_sched #(.PER(TH_PER), .ON(TH_ON)) u_sched (
        .clk(clk), .rst_n(rst_n), .run(supply_ok), .tick(tick), .sense_en(therm_en)
    );

    cps_persist #(.N(OV_TICKS)) u_ov_q (
        .clk(clk), .rst_n(rst_n), .run(supply_ok),
        .flag(ov_flag && !blanking), .adv(tick), .done(ov_done)
    );

    cps_persist #(.N(SYS_TICKS)) u_sys_q (
        .clk(clk), .rst_n(rst_n), .run(supply_ok),
        .flag(sysmon_flag && sys_armed), .adv(tick), .done(sys_done)
    );

    cps_persist #(.N(TH_TICKS)) u_th_q (
        .clk(clk), .rst_n(rst_n), .run(supply_ok),
        .flag(therm_low), .adv(tick && therm_en), .done(th_done)
    );

    assign sys_armed = no_dev || remote_chk;
    assign any_flag  = ov_flag || (sysmon_flag && sys_armed) || therm_low;
    assign blanking  = (blank_cnt != '0);
    assign rec_done  = (rec_cnt == RECOV_LIM);

    // overvoltage blanking after a set-point step-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     blank_cnt <= '0;
        else if (!supply_ok)            blank_cnt <= '0;
        else if (step_dn && !cont_mode) blank_cnt <= BLANK_LD;
        else if (tick && blanking)      blank_cnt <= blank_cnt - 1'b1;
    end

    // quiet-interval counter for hysteretic release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     rec_cnt <= '0;
        else if (!supply_ok || state != S_HYS || any_flag) rec_cnt <= '0;
        else if (tick && !rec_done)                     rec_cnt <= rec_cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_MON:   if (ov_done || sys_done || th_done)
                         state_nx = cfg_latch ? S_LATCH : S_HYS;
            S_HYS:   if (rec_done) state_nx = S_MON;
            S_LATCH: state_nx = S_LATCH;
            default: state_nx = S_MON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state <= S_MON;
        else if (!supply_ok) state <= S_MON;
        else                 state <= state_nx;
    end

    always_comb begin
        prot = (state != S_MON);
        if (cont_mode) ov_sel = class_b ? OVS_MAX_B : OVS_MAX_A;
        else           ov_sel = {1'b0, setpt};
    end

    // R3: continuous mode always selects a class-maximum threshold
    p_cont_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cont_mode |-> (ov_sel[2] && !ov_sel[1]));

    // R1: a qualified overvoltage in monitoring raises protection next clock
    p_ov_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && state == S_MON && ov_done) |=> prot);

    // R8: a latched trip holds while the supply stays good
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || !supply_ok)
        (state == S_LATCH) |=> (state == S_LATCH));

    // R9 / R10: protection only falls after recovery or supply loss
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot) |-> ($past(rec_done) || !$past(supply_ok)));

    // R4: no overvoltage count accumulates while blanked
    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blanking && supply_ok) |=> !ov_done);
endmodule

// File: tb/chg_prot_sup_bench.sv
module chg_prot_sup_bench;
    localparam int DIV = 4, OVT = 3, BLT = 10, SYT = 6, THT = 4;
    localparam int TPER = 5, TON = 2, RCT = 5;

    logic clk = 0, rst_n = 0;
    logic supply_ok = 1, ov_flag = 0, sysmon_flag = 0, therm_low = 0;
    logic no_dev = 0, remote_chk = 0, cont_mode = 0, class_b = 0;
    logic [1:0] setpt = 0;
    logic step_dn = 0, cfg_latch = 0;
    logic [2:0] ov_sel;
    logic therm_en, prot;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    chg_prot_sup #(
        .TICK_DIV(DIV), .OV_TICKS(OVT), .BLANK_TICKS(BLT), .SYS_TICKS(SYT),
        .TH_TICKS(THT), .TH_PER(TPER), .TH_ON(TON), .RECOV_TICKS(RCT)
    ) u_chg_prot_sup (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ov_flag(ov_flag),
        .sysmon_flag(sysmon_flag), .therm_low(therm_low), .no_dev(no_dev),
        .remote_chk(remote_chk), .cont_mode(cont_mode), .class_b(class_b),
        .setpt(setpt), .step_dn(step_dn), .cfg_latch(cfg_latch),
        .ov_sel(ov_sel), .therm_en(therm_en), .prot(prot)
    );

    // behavioural reference model
    int m_tc, m_ph, m_ov, m_sy, m_th, m_bl, m_rc, m_st;
    always @(posedge clk or negedge rst_n) begin
        bit tk, ten, bl, ovd, syd, thd, rcd, arm, anyf;
        if (!rst_n || !supply_ok) begin
            m_tc = 0; m_ph = 0; m_ov = 0; m_sy = 0; m_th = 0;
            m_bl = 0; m_rc = 0; m_st = 0;
        end else begin
            tk = (m_tc == DIV - 1); ten = (m_ph < TON); bl = (m_bl != 0);
            ovd = (m_ov == OVT); syd = (m_sy == SYT); thd = (m_th == THT);
            rcd = (m_rc == RCT);
            arm = no_dev || remote_chk;
            anyf = ov_flag || (sysmon_flag && arm) || therm_low;
            m_tc = tk ? 0 : m_tc + 1;
            if (tk) m_ph = (m_ph == TPER - 1) ? 0 : m_ph + 1;
            if (!ov_flag || bl) m_ov = 0; else if (tk && !ovd) m_ov++;
            if (!(sysmon_flag && arm)) m_sy = 0; else if (tk && !syd) m_sy++;
            if (!therm_low) m_th = 0; else if (tk && ten && !thd) m_th++;
            if (step_dn && !cont_mode) m_bl = BLT; else if (tk && bl) m_bl--;
            if (m_st != 1 || anyf) m_rc = 0; else if (tk && !rcd) m_rc++;
            case (m_st)
                0: if (ovd || syd || thd) m_st = cfg_latch ? 2 : 1;
                1: if (rcd) m_st = 0;
                default: ;
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("model prot R1 R5 R7 R8 R9", prot, m_st != 0);
            chk("model therm_en R6", therm_en, m_ph < TON);
            chk("model ov_sel R2 R3", ov_sel, cont_mode ? (class_b ? 5 : 4) : setpt);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all;
        ov_flag = 0; sysmon_flag = 0; therm_low = 0; no_dev = 0; remote_chk = 0;
        cont_mode = 0; step_dn = 0;
        supply_ok = 0; cyc(1); supply_ok = 1; cyc(1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        cyc(3); rst_n = 1; cyc(1);
        chk("reset prot R10", prot, 0);
        chk("reset ov_sel R2", ov_sel, 0);

        // R2 / R3 threshold selection
        setpt = 2; cyc(1); chk("R2 setpt 12V", ov_sel, 2);
        setpt = 3; cyc(1); chk("R2 setpt 20V", ov_sel, 3);
        cont_mode = 1; class_b = 0; cyc(1); chk("R3 class A max", ov_sel, 4);
        class_b = 1; cyc(1); chk("R3 class B max", ov_sel, 5);
        cont_mode = 0; setpt = 0; cyc(1);

        // R6 duty: any 20-cycle window holds 8 enabled cycles
        hi = 0;
        for (int i = 0; i < 20; i++) begin cyc(1); hi += therm_en; end
        chk("R6 therm_en duty", hi, 8);

        // R1 / R11 short pulses, then a long one (latching)
        cfg_latch = 1;
        ov_flag = 1; cyc(8); ov_flag = 0; cyc(2);
        ov_flag = 1; cyc(8); ov_flag = 0; cyc(4);
        chk("R11 short pulses ignored", prot, 0);
        ov_flag = 1; cyc(20);
        chk("R1 ov trip", prot, 1);
        ov_flag = 0; cyc(40);
        chk("R8 latch holds", prot, 1);
        supply_ok = 0; cyc(1);
        chk("R10 supply clear", prot, 0);
        supply_ok = 1; cyc(2);

        // R9 hysteretic release
        cfg_latch = 0;
        ov_flag = 1; cyc(20); ov_flag = 0; cyc(8);
        chk("R9 still protecting", prot, 1);
        cyc(30);
        chk("R9 released", prot, 0);
        clear_all();

        // R4 blanking after step-down
        step_dn = 1; ov_flag = 1; cyc(1); step_dn = 0; cyc(29);
        chk("R4 blanked", prot, 0);
        cyc(50);
        chk("R4 trip after blanking", prot, 1);
        clear_all();
        cont_mode = 1;
        step_dn = 1; ov_flag = 1; cyc(1); step_dn = 0; cyc(20);
        chk("R4 no blank in continuous", prot, 1);
        clear_all();

        // R5 system monitor gating
        sysmon_flag = 1; cyc(40);
        chk("R5 unarmed ignored", prot, 0);
        no_dev = 1; cyc(40);
        chk("R5 no device trip", prot, 1);
        clear_all();
        remote_chk = 1; sysmon_flag = 1; cyc(40);
        chk("R5 remote trip", prot, 1);
        clear_all();

        // R7 thermal
        therm_low = 1; cyc(12);
        chk("R7 too early", prot, 0);
        cyc(90);
        chk("R7 thermal trip", prot, 1);
        clear_all();
        cyc(5);
        finish_run();
    end
endmodule